// File: doc/BRIEF.md
# Memory Test Address Sequencer

This block is the address and command engine of a built-in self-test for one DRAM module. A start pulse captures a small control word: a walk order, a coverage range and a command. The block then emits a stream of requests over a valid/ready handshake. Each request carries a row, a bank, a column and an operation. Reads that ask for comparison are held in a small in-order queue. A mismatch flag for each of them comes back on a separate return strobe.

The block records the address of the first failing read and sets a sticky fail flag. It counts every later mismatch in a saturating counter. A busy level covers the whole run, including the wait for outstanding compare results, and a one-cycle done pulse closes the run. Two kinds of illegal control word raise a configuration-error flag instead of starting a run: the reserved range code, and a multi-pass algorithm request with a bad range.

Timing, refresh, the physical interface and data generation belong to the surrounding logic.

Top module: `memtest_seq`

## Requirements
- R1: With `order_sel`=00, addresses are walked with the column changing fastest, then the bank, then the row. Each field counts up from its low bound and wraps back to it.
- R2: With `order_sel`=01, the column changes fastest and then the row. With `order_sel`=10, the row changes fastest and then the column. In both orders the bank is held fixed.
- R3: With `order_sel`=11, the bank is held fixed and row and column both step by one on every request, each wrapping at its own bound. After each full lap of rows, the row returns to its low bound and the column restarts at its low bound plus the lap number. The lap number starts at 0. The walk ends after (row count × column count) addresses, and every (row, column) pair is visited exactly once.
- R4: `range_sel`=01 covers only the one address on the `sgl_*` inputs. `range_sel`=10 covers every field from its `beg_*` value to its `fin_*` value inclusive. `range_sel`=11 covers each field from 0 to its `geo_*_max` value.
- R5: In a fixed-bank order (R2, R3), `req_bank` is `beg_bank` under `range_sel`=10 and 0 under `range_sel`=11.
- R6: `req_op` encodes 00 = read without compare, 01 = write, 10 = read with compare. With `cmd_sel` 00, 01 or 10, every request carries that same code.
- R7: With `cmd_sel`=11, each address gets a write (01) and then a read with compare (10) to the same address. The read is the next request after the write is accepted.
- R8: A start is rejected in three cases: `range_sel`=00; `algo_en` high with `range_sel` other than 10; `algo_en` high with the full begin address equal to the full end address. On a rejected start, `cfg_err` is set in the next cycle, `busy` stays low and no request is issued. A later legal start clears `cfg_err`.
- R9: `busy` rises in the cycle after an accepted start and stays high until the last request is accepted and every compare result has returned. `done` is then high for exactly one cycle, in the cycle in which `busy` is first low again. A start while `busy` is high has no effect.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_row`, `req_bank`, `req_col` and `req_op` hold their values.
- R11: The first compare result with `cmp_mismatch` high sets `fail_flag` and copies the row, bank and column of that read into `fail_row`, `fail_bank` and `fail_col`. These outputs do not change for the rest of the run and are cleared by the next accepted start.
- R12: Each mismatch after the first increments `err_count`, which saturates at all ones and is cleared by an accepted start.
- R13: At most `CMP_DEPTH` compare reads are outstanding at any time. When that many are outstanding, a compare read is not offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; the control word and address inputs are sampled here |
| algo_en | input | 1 | Multi-pass algorithm mode requested (range legality check only) |
| order_sel | input | 2 | Walk order: 00 column-bank-row, 01 fast column, 10 fast row, 11 diagonal |
| range_sel | input | 2 | Coverage: 00 reserved, 01 single, 10 begin-to-end, 11 full geometry |
| cmd_sel | input | 2 | Operation: 00 read, 01 write, 10 read-compare, 11 write then read-compare |
| sgl_row | input | ROW_W | Row of the single address |
| sgl_bank | input | BANK_W | Bank of the single address |
| sgl_col | input | COL_W | Column of the single address |
| beg_row | input | ROW_W | Range low row |
| beg_bank | input | BANK_W | Range low bank |
| beg_col | input | COL_W | Range low column |
| fin_row | input | ROW_W | Range high row |
| fin_bank | input | BANK_W | Range high bank |
| fin_col | input | COL_W | Range high column |
| geo_row_max | input | ROW_W | Highest row index of the module |
| geo_bank_max | input | BANK_W | Highest bank index of the module |
| geo_col_max | input | COL_W | Highest column index of the module |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted when high with `req_valid` |
| req_row | output | ROW_W | Request row |
| req_bank | output | BANK_W | Request bank |
| req_col | output | COL_W | Request column |
| req_op | output | 2 | Request operation (R6 encoding) |
| cmp_valid | input | 1 | A compare result returns, in issue order |
| cmp_mismatch | input | 1 | The returning compare failed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last start was rejected |
| fail_flag | output | 1 | A mismatch was seen in this run |
| fail_row | output | ROW_W | Row of the first failing read |
| fail_bank | output | BANK_W | Bank of the first failing read |
| fail_col | output | COL_W | Column of the first failing read |
| err_count | output | ERR_W | Mismatches after the first, saturating |

## Verification
Faults in the walk counters show up at the ports as soon as they happen. A wrong wrap bound or a wrong lap offset puts a wrong address or op into the request stream at the very handshake where it occurs. Faults in the compare queue stay hidden until results come back. A queue that loses or reorders entries reports a wrong failing address, or ends the run early or late, and that shows only when the affected result returns or when `done` fires. The bench therefore compares every accepted request against its own expected list. It checks the fail capture, the counter and the single done pulse at the end of each run, and it holds back compare returns long enough to fill the queue.

// File: rtl/mts_pkg.sv
package mts_pkg;

  typedef enum logic [1:0] {
    ORD_CBR      = 2'b00,
    ORD_FAST_COL = 2'b01,
    ORD_FAST_ROW = 2'b10,
    ORD_DIAG     = 2'b11
  } order_e;

  typedef enum logic [1:0] {
    RNG_RSVD   = 2'b00,
    RNG_SINGLE = 2'b01,
    RNG_SPAN   = 2'b10,
    RNG_FULL   = 2'b11
  } range_e;

  localparam logic [1:0] OP_RD   = 2'b00;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] OP_RDC  = 2'b10;
  localparam logic [1:0] CMD_WRRD = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_DRAIN = 2'b10
  } seq_state_e;

endpackage

// File: rtl/mts_walker.sv
module mts_walker #(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [1:0]        order,
  input  logic [ROW_W-1:0]  lo_row_i,
  input  logic [ROW_W-1:0]  hi_row_i,
  input  logic [BANK_W-1:0] lo_bank_i,
  input  logic [BANK_W-1:0] hi_bank_i,
  input  logic [COL_W-1:0]  lo_col_i,
  input  logic [COL_W-1:0]  hi_col_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic              last_o
);
  import mts_pkg::*;

  logic [ROW_W-1:0]  lr, hr, r_q, r_d;
  logic [BANK_W-1:0] lb, hb, b_q, b_d;
  logic [COL_W-1:0]  lc, hc, c_q, c_d, lap_q, lap_d;
  logic row_end, bank_end, col_end, lap_end;

  function automatic logic [ROW_W-1:0] f_row_inc(input logic [ROW_W-1:0] v,
                                                 input logic [ROW_W-1:0] lo,
                                                 input logic [ROW_W-1:0] hi);
    return (v == hi) ? lo : v + 1'b1;
  endfunction

  function automatic logic [BANK_W-1:0] f_bank_inc(input logic [BANK_W-1:0] v,
                                                   input logic [BANK_W-1:0] lo,
                                                   input logic [BANK_W-1:0] hi);
    return (v == hi) ? lo : v + 1'b1;
  endfunction

  function automatic logic [COL_W-1:0] f_col_inc(input logic [COL_W-1:0] v,
                                                 input logic [COL_W-1:0] lo,
                                                 input logic [COL_W-1:0] hi);
    return (v == hi) ? lo : v + 1'b1;
  endfunction

  assign row_end  = (r_q == hr);
  assign bank_end = (b_q == hb);
  assign col_end  = (c_q == hc);
  assign lap_end  = (lap_q == (hc - lc));

  always_comb begin
    r_d   = r_q;
    b_d   = b_q;
    c_d   = c_q;
    lap_d = lap_q;
    unique case (order)
      ORD_CBR: begin
        c_d = f_col_inc(c_q, lc, hc);
        if (col_end) begin
          b_d = f_bank_inc(b_q, lb, hb);
          if (bank_end) r_d = f_row_inc(r_q, lr, hr);
        end
      end
      ORD_FAST_COL: begin
        c_d = f_col_inc(c_q, lc, hc);
        if (col_end) r_d = f_row_inc(r_q, lr, hr);
      end
      ORD_FAST_ROW: begin
        r_d = f_row_inc(r_q, lr, hr);
        if (row_end) c_d = f_col_inc(c_q, lc, hc);
      end
      default: begin
        if (row_end) begin
          r_d   = lr;
          lap_d = lap_q + 1'b1;
          c_d   = lc + lap_q + 1'b1;
        end else begin
          r_d = f_row_inc(r_q, lr, hr);
          c_d = f_col_inc(c_q, lc, hc);
        end
      end
    endcase
  end

  always_comb begin
    unique case (order)
      ORD_CBR:  last_o = row_end && bank_end && col_end;
      ORD_DIAG: last_o = row_end && lap_end;
      default:  last_o = row_end && col_end;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr <= '0; hr <= '0; lb <= '0; hb <= '0; lc <= '0; hc <= '0;
      r_q <= '0; b_q <= '0; c_q <= '0; lap_q <= '0;
    end else if (load) begin
      lr <= lo_row_i;  hr <= hi_row_i;
      lb <= lo_bank_i; hb <= hi_bank_i;
      lc <= lo_col_i;  hc <= hi_col_i;
      r_q <= lo_row_i; b_q <= lo_bank_i; c_q <= lo_col_i;
      lap_q <= '0;
    end else if (advance) begin
      r_q <= r_d; b_q <= b_d; c_q <= c_d; lap_q <= lap_d;
    end
  end

  assign row_o  = r_q;
  assign bank_o = b_q;
  assign col_o  = c_q;

endmodule

// File: rtl/mts_cmp_fifo.sv
module mts_cmp_fifo #(
  parameter int W     = 27,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] f_ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= f_ptr_inc(wp);
      if (do_pop)  rp <= f_ptr_inc(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign count = cnt;

endmodule

// File: rtl/mts_result.sv
module mts_result #(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hit,
  input  logic              mismatch,
  input  logic [ROW_W-1:0]  hit_row,
  input  logic [BANK_W-1:0] hit_bank,
  input  logic [COL_W-1:0]  hit_col,
  output logic              fail_o,
  output logic [ROW_W-1:0]  fail_row_o,
  output logic [BANK_W-1:0] fail_bank_o,
  output logic [COL_W-1:0]  fail_col_o,
  output logic [ERR_W-1:0]  err_cnt_o
);

  function automatic logic [ERR_W-1:0] f_sat_inc(input logic [ERR_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fail_o      <= 1'b0;
      fail_row_o  <= '0;
      fail_bank_o <= '0;
      fail_col_o  <= '0;
      err_cnt_o   <= '0;
    end else if (hit && mismatch) begin
      if (!fail_o) begin
        fail_o      <= 1'b1;
        fail_row_o  <= hit_row;
        fail_bank_o <= hit_bank;
        fail_col_o  <= hit_col;
      end else begin
        err_cnt_o <= f_sat_inc(err_cnt_o);
      end
    end
  end

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq #(
  parameter int ROW_W     = 14,
  parameter int BANK_W    = 3,
  parameter int COL_W     = 10,
  parameter int CMP_DEPTH = 4,
  parameter int ERR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              algo_en,
  input  logic [1:0]        order_sel,
  input  logic [1:0]        range_sel,
  input  logic [1:0]        cmd_sel,
  input  logic [ROW_W-1:0]  sgl_row,
  input  logic [BANK_W-1:0] sgl_bank,
  input  logic [COL_W-1:0]  sgl_col,
  input  logic [ROW_W-1:0]  beg_row,
  input  logic [BANK_W-1:0] beg_bank,
  input  logic [COL_W-1:0]  beg_col,
  input  logic [ROW_W-1:0]  fin_row,
  input  logic [BANK_W-1:0] fin_bank,
  input  logic [COL_W-1:0]  fin_col,
  input  logic [ROW_W-1:0]  geo_row_max,
  input  logic [BANK_W-1:0] geo_bank_max,
  input  logic [COL_W-1:0]  geo_col_max,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ROW_W-1:0]  req_row,
  output logic [BANK_W-1:0] req_bank,
  output logic [COL_W-1:0]  req_col,
  output logic [1:0]        req_op,
  input  logic              cmp_valid,
  input  logic              cmp_mismatch,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic              fail_flag,
  output logic [ROW_W-1:0]  fail_row,
  output logic [BANK_W-1:0] fail_bank,
  output logic [COL_W-1:0]  fail_col,
  output logic [ERR_W-1:0]  err_count
);
  import mts_pkg::*;

  localparam int ADDR_W = ROW_W + BANK_W + COL_W;
  localparam int CNT_W  = $clog2(CMP_DEPTH + 1);

  seq_state_e        state_q;
  logic [1:0]        ord_q, cmd_q;
  logic              phase_rd_q, cfg_err_q, done_q;

  logic              cfg_bad, run_start, cfg_reject;
  logic              fixed_walk, wrrd_mode, wr_half;
  logic              op_cmp, req_hs, walk_step, final_hs, cmp_take;
  logic [1:0]        cur_op;
  logic [ROW_W-1:0]  lo_row, hi_row;
  logic [BANK_W-1:0] lo_bank, hi_bank;
  logic [COL_W-1:0]  lo_col, hi_col;
  logic              walk_last;
  logic [ADDR_W-1:0] head_addr;
  logic              q_full, q_empty;
  logic [CNT_W-1:0]  cmp_pending;

  // legality of the control word presented with start
  assign cfg_bad = (range_sel == RNG_RSVD) ||
                   (algo_en && ((range_sel != RNG_SPAN) ||
                                ({beg_row, beg_bank, beg_col} == {fin_row, fin_bank, fin_col})));
  assign run_start  = start && (state_q == ST_IDLE) && !cfg_bad;
  assign cfg_reject = start && (state_q == ST_IDLE) && cfg_bad;

  // walk bounds from range mode; fixed-bank orders pin the bank
  always_comb begin
    unique case (range_sel)
      RNG_SINGLE: begin
        lo_row = sgl_row;  hi_row = sgl_row;
        lo_bank = sgl_bank; hi_bank = sgl_bank;
        lo_col = sgl_col;  hi_col = sgl_col;
      end
      RNG_SPAN: begin
        lo_row = beg_row;  hi_row = fin_row;
        lo_bank = beg_bank; hi_bank = fin_bank;
        lo_col = beg_col;  hi_col = fin_col;
      end
      default: begin
        lo_row = '0; hi_row = geo_row_max;
        lo_bank = '0; hi_bank = geo_bank_max;
        lo_col = '0; hi_col = geo_col_max;
      end
    endcase
    if (order_sel != ORD_CBR) hi_bank = lo_bank;
  end

  assign fixed_walk = (ord_q != ORD_CBR);
  assign wrrd_mode  = (cmd_q == CMD_WRRD);
  assign wr_half    = wrrd_mode && !phase_rd_q;
  assign cur_op     = wrrd_mode ? (phase_rd_q ? OP_RDC : OP_WR) : cmd_q;
  assign op_cmp     = (cur_op == OP_RDC);

  assign req_valid  = (state_q == ST_ISSUE) && !(op_cmp && q_full);
  assign req_hs     = req_valid && req_ready;
  assign walk_step  = req_hs && !wr_half && !walk_last;
  assign final_hs   = req_hs && !wr_half && walk_last;
  assign cmp_take   = cmp_valid && !q_empty;

  mts_walker #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (run_start),
    .advance   (walk_step),
    .order     (ord_q),
    .lo_row_i  (lo_row),
    .hi_row_i  (hi_row),
    .lo_bank_i (lo_bank),
    .hi_bank_i (hi_bank),
    .lo_col_i  (lo_col),
    .hi_col_i  (hi_col),
    .row_o     (req_row),
    .bank_o    (req_bank),
    .col_o     (req_col),
    .last_o    (walk_last)
  );

  mts_cmp_fifo #(.W(ADDR_W), .DEPTH(CMP_DEPTH)) u_cmpq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_hs && op_cmp),
    .din   ({req_row, req_bank, req_col}),
    .pop   (cmp_take),
    .dout  (head_addr),
    .full  (q_full),
    .empty (q_empty),
    .count (cmp_pending)
  );

  mts_result #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .ERR_W(ERR_W)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (run_start),
    .hit         (cmp_take),
    .mismatch    (cmp_mismatch),
    .hit_row     (head_addr[ADDR_W-1 -: ROW_W]),
    .hit_bank    (head_addr[COL_W +: BANK_W]),
    .hit_col     (head_addr[COL_W-1:0]),
    .fail_o      (fail_flag),
    .fail_row_o  (fail_row),
    .fail_bank_o (fail_bank),
    .fail_col_o  (fail_col),
    .err_cnt_o   (err_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ord_q      <= '0;
      cmd_q      <= '0;
      phase_rd_q <= 1'b0;
      cfg_err_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_reject) cfg_err_q <= 1'b1;
      if (run_start) begin
        cfg_err_q  <= 1'b0;
        ord_q      <= order_sel;
        cmd_q      <= cmd_sel;
        phase_rd_q <= 1'b0;
      end else if (req_hs && wrrd_mode) begin
        phase_rd_q <= !phase_rd_q;
      end
      unique case (state_q)
        ST_IDLE:  if (run_start) state_q <= ST_ISSUE;
        ST_ISSUE: if (final_hs)  state_q <= ST_DRAIN;
        default: begin
          if (q_empty) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign req_op  = cur_op;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign cfg_err = cfg_err_q;

endmodule

// File: rtl/memtest_seq_chk.sv
module memtest_seq_chk #(
  parameter int ROW_W     = 14,
  parameter int BANK_W    = 3,
  parameter int COL_W     = 10,
  parameter int CMP_DEPTH = 4,
  parameter int ERR_W     = 16
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             req_valid,
  input logic                             req_ready,
  input logic [ROW_W-1:0]                 req_row,
  input logic [BANK_W-1:0]                req_bank,
  input logic [COL_W-1:0]                 req_col,
  input logic [1:0]                       req_op,
  input logic                             busy,
  input logic                             done,
  input logic                             cfg_err,
  input logic                             fail_flag,
  input logic [ROW_W-1:0]                 fail_row,
  input logic [BANK_W-1:0]                fail_bank,
  input logic [COL_W-1:0]                 fail_col,
  input logic [ERR_W-1:0]                 err_count,
  input logic                             run_start,
  input logic                             wrrd_mode,
  input logic                             fixed_walk,
  input logic [$clog2(CMP_DEPTH+1)-1:0]   cmp_pending
);

  // R10: offered request holds until taken
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row) && $stable(req_bank)
                                   && $stable(req_col) && $stable(req_op)));

  // R9: nothing offered outside a run
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R9: done marks the first idle cycle
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: a rejected start never runs
  p_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  // R7: write is followed by a compare read of the same address
  p_wrrd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && wrrd_mode && req_op == 2'b01) |=>
      (req_op == 2'b10 && $stable(req_row) && $stable(req_bank) && $stable(req_col)));

  // R5: bank never moves in a fixed-bank walk
  p_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && fixed_walk) |=> $stable(req_bank));

  // R13: outstanding compares bounded
  p_depth_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pending <= ($clog2(CMP_DEPTH+1))'(CMP_DEPTH));

  // R11: capture is sticky within a run
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !run_start) |=> (fail_flag && $stable(fail_row)
                                   && $stable(fail_bank) && $stable(fail_col)));

  // R12: counter saturates
  p_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((&err_count) && !run_start) |=> (&err_count));

endmodule

bind memtest_seq memtest_seq_chk #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .CMP_DEPTH(CMP_DEPTH), .ERR_W(ERR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_row     (req_row),
  .req_bank    (req_bank),
  .req_col     (req_col),
  .req_op      (req_op),
  .busy        (busy),
  .done        (done),
  .cfg_err     (cfg_err),
  .fail_flag   (fail_flag),
  .fail_row    (fail_row),
  .fail_bank   (fail_bank),
  .fail_col    (fail_col),
  .err_count   (err_count),
  .run_start   (run_start),
  .wrrd_mode   (wrrd_mode),
  .fixed_walk  (fixed_walk),
  .cmp_pending (cmp_pending)
);

// File: tb/memtest_seq_bench.sv
`timescale 1ns/1ps
module memtest_seq_bench;
  localparam int RW = 3, BW = 2, CW = 3, DEP = 2, EW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, algo_en = 0, req_ready = 0, cmp_valid = 0, cmp_mismatch = 0;
  logic [1:0] order_sel = 0, range_sel = 0, cmd_sel = 0;
  logic [RW-1:0] sgl_row = 0, beg_row = 0, fin_row = 0, geo_row_max = 0;
  logic [BW-1:0] sgl_bank = 0, beg_bank = 0, fin_bank = 0, geo_bank_max = 0;
  logic [CW-1:0] sgl_col = 0, beg_col = 0, fin_col = 0, geo_col_max = 0;
  logic req_valid, busy, done, cfg_err, fail_flag;
  logic [RW-1:0] req_row, fail_row;
  logic [BW-1:0] req_bank, fail_bank;
  logic [CW-1:0] req_col, fail_col;
  logic [1:0] req_op;
  logic [EW-1:0] err_count;

  always #2.5 clk = ~clk;

  memtest_seq #(.ROW_W(RW), .BANK_W(BW), .COL_W(CW), .CMP_DEPTH(DEP), .ERR_W(EW)) u_memtest_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .algo_en(algo_en),
    .order_sel(order_sel), .range_sel(range_sel), .cmd_sel(cmd_sel),
    .sgl_row(sgl_row), .sgl_bank(sgl_bank), .sgl_col(sgl_col),
    .beg_row(beg_row), .beg_bank(beg_bank), .beg_col(beg_col),
    .fin_row(fin_row), .fin_bank(fin_bank), .fin_col(fin_col),
    .geo_row_max(geo_row_max), .geo_bank_max(geo_bank_max), .geo_col_max(geo_col_max),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_bank(req_bank), .req_col(req_col), .req_op(req_op),
    .cmp_valid(cmp_valid), .cmp_mismatch(cmp_mismatch),
    .busy(busy), .done(done), .cfg_err(cfg_err),
    .fail_flag(fail_flag), .fail_row(fail_row), .fail_bank(fail_bank), .fail_col(fail_col),
    .err_count(err_count)
  );

  typedef struct { int row; int bank; int col; int op; } req_t;
  req_t exp_q[$];
  req_t ret_q[$];
  int n_chk = 0, n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;
  int ret_idx, mm_mask, hold_off, done_seen;
  bit exp_fail; int exp_frow, exp_fbank, exp_fcol, exp_err;
  bit held; req_t held_r;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void add_addr(int r, int b, int c, int cmd);
    req_t x;
    x.row = r; x.bank = b; x.col = c;
    if (cmd == 3) begin
      x.op = 1; exp_q.push_back(x);
      x.op = 2; exp_q.push_back(x);
    end else begin
      x.op = cmd; exp_q.push_back(x);
    end
  endfunction

  // reference walk from the requirements
  task automatic build();
    int lr, hr, lb, hb, lc, hc, nr, nc;
    exp_q.delete();
    if (range_sel == 2'b01) begin
      lr = sgl_row; hr = sgl_row; lb = sgl_bank; hb = sgl_bank; lc = sgl_col; hc = sgl_col;
    end else if (range_sel == 2'b10) begin
      lr = beg_row; hr = fin_row; lb = beg_bank; hb = fin_bank; lc = beg_col; hc = fin_col;
    end else begin
      lr = 0; hr = geo_row_max; lb = 0; hb = geo_bank_max; lc = 0; hc = geo_col_max;
    end
    if (order_sel != 0) hb = lb;
    nr = hr - lr + 1; nc = hc - lc + 1;
    case (order_sel)
      2'd0: for (int r = lr; r <= hr; r++) for (int b = lb; b <= hb; b++)
              for (int c = lc; c <= hc; c++) add_addr(r, b, c, cmd_sel);
      2'd1: for (int r = lr; r <= hr; r++) for (int c = lc; c <= hc; c++) add_addr(r, lb, c, cmd_sel);
      2'd2: for (int c = lc; c <= hc; c++) for (int r = lr; r <= hr; r++) add_addr(r, lb, c, cmd_sel);
      default: for (int d = 0; d < nc; d++) for (int k = 0; k < nr; k++)
                 add_addr(lr + k, lb, lc + (k + d) % nc, cmd_sel);
    endcase
  endtask

  // one clock of stimulus and comparison, at the falling edge
  task automatic cycle(input string tag);
    req_t x;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (done) begin
      done_seen++;
      chk(busy == 0, "R9", "busy low with done", busy, 0);
    end
    if (!busy) chk(req_valid == 0, "R9", "no request while idle", req_valid, 0);
    if (held) begin
      chk(req_valid == 1, "R10", "valid held", req_valid, 1);
      chk(req_row == held_r.row && req_col == held_r.col && req_bank == held_r.bank
          && req_op == held_r.op, "R10", "fields held", req_row, held_r.row);
    end
    cmp_valid = 0; cmp_mismatch = 0;
    if (hold_off > 0) hold_off--;
    else if (ret_q.size() > 0 && lfsr[3]) begin
      x = ret_q.pop_front();
      cmp_valid = 1;
      cmp_mismatch = (ret_idx < 32) ? mm_mask[ret_idx] : 1'b0;
      if (cmp_mismatch) begin
        if (!exp_fail) begin
          exp_fail = 1; exp_frow = x.row; exp_fbank = x.bank; exp_fcol = x.col;
        end else if (exp_err < (1 << EW) - 1) exp_err++;
      end
      ret_idx++;
    end
    req_ready = lfsr[0] | lfsr[5];
    held = 0;
    if (req_valid && req_ready) begin
      if (exp_q.size() == 0) chk(0, tag, "extra request", req_row, -1);
      else begin
        x = exp_q.pop_front();
        chk(req_row == x.row, tag, "row", req_row, x.row);
        chk(req_bank == x.bank, tag, "bank", req_bank, x.bank);
        chk(req_col == x.col, tag, "col", req_col, x.col);
        chk(req_op == x.op, "R6", "op", req_op, x.op);
        if (x.op == 2) ret_q.push_back(x);
      end
      chk(ret_q.size() <= DEP, "R13", "outstanding compares", ret_q.size(), DEP);
    end else if (req_valid) begin
      held = 1; held_r.row = req_row; held_r.bank = req_bank; held_r.col = req_col; held_r.op = req_op;
    end
  endtask

  task automatic run(input string tag, input int mask, input int hold, input int poke);
    int n;
    build();
    ret_q.delete(); ret_idx = 0; mm_mask = mask; hold_off = hold; done_seen = 0;
    exp_fail = 0; exp_err = 0; held = 0;
    @(negedge clk); start = 1; req_ready = 0; cmp_valid = 0;
    @(negedge clk); start = 0;
    chk(busy == 1, "R9", "busy after start", busy, 1);
    chk(cfg_err == 0, "R8", "cfg_err cleared by legal start", cfg_err, 0);
    n = 0;
    while (done_seen == 0 && n < 4000) begin
      if (n == poke) begin start = 1; cmd_sel = ~cmd_sel; end
      cycle(tag);
      if (n == poke) begin start = 0; cmd_sel = ~cmd_sel; end
      n++;
    end
    chk(done_seen == 1, "R9", "done pulse seen", done_seen, 1);
    chk(exp_q.size() == 0, tag, "requests left over", exp_q.size(), 0);
    chk(ret_q.size() == 0, "R9", "compares left over at done", ret_q.size(), 0);
    repeat (3) cycle(tag);
    chk(done_seen == 1, "R9", "single done pulse", done_seen, 1);
    chk(fail_flag == exp_fail, "R11", "fail flag", fail_flag, exp_fail);
    if (exp_fail) begin
      chk(fail_row == exp_frow, "R11", "fail row", fail_row, exp_frow);
      chk(fail_bank == exp_fbank, "R11", "fail bank", fail_bank, exp_fbank);
      chk(fail_col == exp_fcol, "R11", "fail col", fail_col, exp_fcol);
    end
    chk(err_count == exp_err, "R12", "error count", err_count, exp_err);
  endtask

  task automatic reject(input string what);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(cfg_err == 1, "R8", what, cfg_err, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(busy == 0 && req_valid == 0, "R8", what, {busy, req_valid}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R9", "reset busy", busy, 0);
    chk(req_valid == 0 && done == 0, "R9", "reset valid/done", req_valid, 0);
    chk(cfg_err == 0, "R8", "reset cfg_err", cfg_err, 0);
    chk(fail_flag == 0 && err_count == 0, "R11", "reset fail state", fail_flag, 0);

    // R1: column-bank-row span, writes; a start mid-run must be ignored (R9)
    order_sel = 0; range_sel = 2; cmd_sel = 1;
    beg_row = 1; beg_bank = 1; beg_col = 2; fin_row = 2; fin_bank = 2; fin_col = 4;
    run("R1", 0, 0, 5);

    // R2/R5: fast column over full geometry, bank 0, plain reads
    order_sel = 1; range_sel = 3; cmd_sel = 0;
    geo_row_max = 2; geo_bank_max = 3; geo_col_max = 3;
    run("R2", 0, 0, -1);

    // R2/R5: fast row in a span, bank pinned to begin bank, compares with mismatches
    order_sel = 2; range_sel = 2; cmd_sel = 2;
    beg_row = 1; beg_bank = 2; beg_col = 0; fin_row = 3; fin_bank = 3; fin_col = 2;
    run("R5", 32'b101100, 0, -1);

    // R3/R7: diagonal over full geometry, write then compare
    order_sel = 3; range_sel = 3; cmd_sel = 3;
    geo_row_max = 2; geo_bank_max = 1; geo_col_max = 3;
    run("R3", 32'b1, 0, -1);

    // R4/R7: single location, write then compare; R11 state cleared by start
    order_sel = 3; range_sel = 1; cmd_sel = 3;
    sgl_row = 5; sgl_bank = 1; sgl_col = 6;
    run("R4", 0, 0, -1);

    // R8: illegal control words
    range_sel = 0; reject("reserved range rejected");
    algo_en = 1; range_sel = 3; reject("algorithm with full range rejected");
    range_sel = 2; beg_row = 2; beg_bank = 1; beg_col = 3;
    fin_row = 2; fin_bank = 1; fin_col = 3;
    reject("algorithm with equal bounds rejected");

    // R8: legal algorithm span runs and clears cfg_err
    order_sel = 0; cmd_sel = 1; fin_row = 3; fin_col = 4;
    run("R8", 0, 0, -1);
    algo_en = 0;

    // R12/R13: all compares fail, returns held back to fill the queue
    order_sel = 1; range_sel = 2; cmd_sel = 2;
    beg_row = 0; beg_bank = 3; beg_col = 1; fin_row = 2; fin_bank = 3; fin_col = 4;
    run("R12", 32'hFFFF_FFFF, 30, -1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule